// File: doc/BRIEF.md
# Two-Stage SPI Receive Staging Buffer

This block sits between an SPI shifter and the register file of an SPI controller. Each word the shifter completes comes with a three-bit error status. The block keeps the word in one of two places. The first is a visible stage that software reads. The second is a hidden internal stage behind it. A word that arrives while the visible stage is empty goes straight into the visible stage. A word that arrives while the visible stage is occupied waits in the internal stage. A word that arrives while both stages are occupied overwrites the internal stage. This is an overrun: the block raises a sticky flag and marks the overwritten entry.

Software uses plain strobes. A read strobe consumes the visible word. Write-one-to-clear strobes act on the receive-full flag and on the overrun flag. Each time the visible stage is consumed, the internal stage moves forward in the same update. Reads do not clear the overrun flag. As a result, software may need two reads to reach the word that caused the overrun. Dropping the module enable empties both stages and clears every flag. Each interrupt output is a level: its flag ANDed with its enable.

The input side is a valid/ready stream that never applies back-pressure while the block is enabled. `in_ready` equals `enable`. A word is taken on every clock edge where `in_valid` and `in_ready` are both high, whatever the buffer occupancy. When the block is disabled, `in_ready` is low and words are dropped.

Top module: `spi_rx_stage`

## Requirements
- R1: A word accepted while the visible stage is empty appears on `rd_data`/`rd_err` one clock later, with `rx_full`=1, `rx_empty`=0 and `rd_ovr`=0.
- R2: A word accepted while the visible stage is full and the internal stage is empty is held internally. The visible outputs do not change, and the held word becomes visible after the next read.
- R3: A `rd_strobe` while the visible stage is full consumes that word. If the internal stage is full, its entry becomes visible on the same edge and `rx_full` stays 1. Otherwise `rx_full` becomes 0.
- R4: A `clr_full` pulse discards the visible word in the same way as a read, including the immediate forward move from the internal stage.
- R5: A word accepted while both stages stay full overwrites the internal entry. It sets `ovr_flag`, and that entry's overrun bit is seen as `rd_ovr`=1 once it becomes visible.
- R6: `ovr_flag` is sticky across reads and clears only on `clr_ovr` or on disable. A set in the same cycle as `clr_ovr` wins.
- R7: An `err_valid` pulse without a word completion, while both stages stay full, sets `ovr_flag`. It also sets the internal entry's overrun bit and replaces that entry's error field with `err_code`. In the error field, bit 0 is timeout, bit 1 is bit error and bit 2 is length error.
- R8: With `enable`=0, both stages empty and both flags clear on the next edge, `in_ready` is 0, and every data and strobe input is ignored.
- R9: `irq_rx` equals `rx_full` AND `rx_ie`, and `irq_ovr` equals `ovr_flag` AND `ovr_ie`, combinationally.
- R10: After reset, `rx_full`=0, `rx_empty`=1, `ovr_flag`=0, and `rd_data`, `rd_err` and `rd_ovr` are 0.
- R11: A `rd_strobe` or `clr_full` while the visible stage is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; 0 flushes and holds the block idle |
| in_valid | input | 1 | Shifter has a completed word |
| in_ready | output | 1 | Word accepted when high (equals enable) |
| in_data | input | DATA_W | Completed word |
| in_err | input | 3 | Error status of the completed word |
| err_valid | input | 1 | Mid-transfer error report |
| err_code | input | 3 | Error status of the mid-transfer report |
| rd_strobe | input | 1 | Software read of the visible word |
| clr_full | input | 1 | Write-one-to-clear of the receive-full flag |
| clr_ovr | input | 1 | Write-one-to-clear of the overrun flag |
| rx_ie | input | 1 | Receive interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rd_data | output | DATA_W | Visible word |
| rd_err | output | 3 | Error status of the visible word |
| rd_ovr | output | 1 | Overrun mark of the visible word |
| rx_full | output | 1 | Receive-full flag |
| rx_empty | output | 1 | Visible stage empty |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_rx | output | 1 | Receive interrupt request (level) |
| irq_ovr | output | 1 | Overrun interrupt request (level) |

## Verification
Stage contents and both flags are registered, so a stimulus applied before an edge shows up on `rd_data`, `rd_err`, `rd_ovr`, `rx_full`, `rx_empty` and `ovr_flag` exactly one edge later. The interrupt outputs and `in_ready` follow combinationally from those registers and the enables, in the same cycle. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares every output on the next falling edge. A bench model applies the requirements to each cycle and supplies the expected values. The sweep covers every start occupancy (0, 1 or 2 words) against all 32 combinations of the read, clear, word and error strobes, and interrupt enables that vary with the pattern.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int ERR_W      = 3;
  localparam int ERR_TMO    = 0;
  localparam int ERR_BIT    = 1;
  localparam int ERR_LEN    = 2;
  localparam int NUM_IRQ    = 2;
  localparam int IRQ_RX     = 0;
  localparam int IRQ_OVR    = 1;

  function automatic int entry_width(input int data_w);
    return data_w + ERR_W + 1;
  endfunction
endpackage

// File: rtl/spi_rx_slot.sv
module spi_rx_slot #(
  parameter int DATA_W = 16,
  parameter int ERR_W  = 3,
  localparam int ENT_W = DATA_W + ERR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [ENT_W-1:0] load_val,
  input  logic             drop,
  input  logic             mark,
  input  logic [ERR_W-1:0] mark_err,
  output logic             full,
  output logic [ENT_W-1:0] q
);
  localparam int OVR_POS = ENT_W - 1;
  localparam int ERR_LO  = DATA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (flush) begin
      full <= 1'b0;
      q    <= '0;
    end else if (load) begin
      full <= 1'b1;
      q    <= load_val;
    end else if (drop) begin
      full <= 1'b0;
    end else if (mark) begin
      q[OVR_POS]                 <= 1'b1;
      q[ERR_LO +: ERR_W]         <= mark_err;
    end
  end
endmodule

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl (
  input  logic enable,
  input  logic take,
  input  logic err_valid,
  input  logic rd_strobe,
  input  logic clr_full,
  input  logic vis_full,
  input  logic int_full,
  output logic vis_load,
  output logic vis_from_int,
  output logic vis_drop,
  output logic int_load,
  output logic int_drop,
  output logic int_mark,
  output logic new_ovr,
  output logic ovr_set
);
  logic pop, vis_left, fwd, vis_mid, int_mid, vis_take;

  always_comb begin
    pop      = enable & vis_full & (rd_strobe | clr_full);
    vis_left = vis_full & ~pop;
    fwd      = enable & ~vis_left & int_full;
    vis_mid  = vis_left | fwd;
    int_mid  = int_full & ~fwd;
    vis_take = take & ~vis_mid;

    vis_load     = fwd | vis_take;
    vis_from_int = fwd;
    vis_drop     = pop & ~vis_load;

    int_load = take & vis_mid;
    new_ovr  = int_mid;
    int_drop = fwd & ~int_load;
    int_mark = enable & err_valid & ~take & vis_mid & int_mid;

    ovr_set  = (int_load & int_mid) | int_mark;
  end
endmodule

// File: rtl/spi_rx_irq.sv
module spi_rx_irq #(
  parameter int N = 2
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] ena,
  output logic [N-1:0] irq
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign irq[g] = flag[g] & ena[g];
  end
endmodule

// File: rtl/spi_rx_stage.sv
module spi_rx_stage
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ERR_W-1:0]  in_err,
  input  logic              err_valid,
  input  logic [ERR_W-1:0]  err_code,
  input  logic              rd_strobe,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              rx_ie,
  input  logic              ovr_ie,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err,
  output logic              rd_ovr,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              ovr_flag,
  output logic              irq_rx,
  output logic              irq_ovr
);
  localparam int ENT_W = entry_width(DATA_W);

  logic             take;
  logic             vis_full, int_full;
  logic [ENT_W-1:0] vis_q, int_q, vis_in, int_in;
  logic             vis_load, vis_from_int, vis_drop;
  logic             int_load, int_drop, int_mark, new_ovr, ovr_set;
  logic [NUM_IRQ-1:0] irq_flags, irq_ena, irq_vec;

  assign in_ready = enable;
  assign take     = in_valid & enable;

  spi_rx_ctrl u_ctrl (
    .enable      (enable),
    .take        (take),
    .err_valid   (err_valid),
    .rd_strobe   (rd_strobe),
    .clr_full    (clr_full),
    .vis_full    (vis_full),
    .int_full    (int_full),
    .vis_load    (vis_load),
    .vis_from_int(vis_from_int),
    .vis_drop    (vis_drop),
    .int_load    (int_load),
    .int_drop    (int_drop),
    .int_mark    (int_mark),
    .new_ovr     (new_ovr),
    .ovr_set     (ovr_set)
  );

  assign vis_in = vis_from_int ? int_q : {1'b0, in_err, in_data};
  assign int_in = {new_ovr, in_err, in_data};

  spi_rx_slot #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_vis (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (~enable),
    .load    (vis_load),
    .load_val(vis_in),
    .drop    (vis_drop),
    .mark    (1'b0),
    .mark_err(err_code),
    .full    (vis_full),
    .q       (vis_q)
  );

  spi_rx_slot #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_int (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (~enable),
    .load    (int_load),
    .load_val(int_in),
    .drop    (int_drop),
    .mark    (int_mark),
    .mark_err(err_code),
    .full    (int_full),
    .q       (int_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovr_flag <= 1'b0;
    else if (!enable)    ovr_flag <= 1'b0;
    else if (ovr_set)    ovr_flag <= 1'b1;
    else if (clr_ovr)    ovr_flag <= 1'b0;
  end

  assign rd_data  = vis_q[DATA_W-1:0];
  assign rd_err   = vis_q[DATA_W +: ERR_W];
  assign rd_ovr   = vis_q[ENT_W-1];
  assign rx_full  = vis_full;
  assign rx_empty = ~vis_full;

  assign irq_flags[IRQ_RX]  = vis_full;
  assign irq_flags[IRQ_OVR] = ovr_flag;
  assign irq_ena[IRQ_RX]    = rx_ie;
  assign irq_ena[IRQ_OVR]   = ovr_ie;

  spi_rx_irq #(.N(NUM_IRQ)) u_irq (
    .flag(irq_flags),
    .ena (irq_ena),
    .irq (irq_vec)
  );

  assign irq_rx  = irq_vec[IRQ_RX];
  assign irq_ovr = irq_vec[IRQ_OVR];
endmodule

// File: rtl/spi_rx_stage_chk.sv
module spi_rx_stage_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic in_valid,
  input logic rd_strobe,
  input logic clr_full,
  input logic clr_ovr,
  input logic rx_ie,
  input logic ovr_ie,
  input logic rx_full,
  input logic rx_empty,
  input logic ovr_flag,
  input logic irq_rx,
  input logic irq_ovr,
  input logic int_full
);
  // R2: the hidden stage is never occupied ahead of the visible one
  a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
    int_full |-> rx_full);

  // R1: an accepted word always leaves the visible stage occupied
  a_r1_arrive: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && in_valid) |=> rx_full);

  // R6: overrun flag is sticky unless cleared or disabled
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && enable && !clr_ovr) |=> ovr_flag);

  // R8: disable flushes the flags
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rx_full && !ovr_flag));

  // R4: discarding with nothing behind leaves the stage empty
  a_r4_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr_full && !int_full && !in_valid) |=> rx_empty);

  // R9: interrupt levels follow flag and enable
  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx == (rx_full && rx_ie)) && (irq_ovr == (ovr_flag && ovr_ie)));
endmodule

bind spi_rx_stage spi_rx_stage_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .in_valid (in_valid),
  .rd_strobe(rd_strobe),
  .clr_full (clr_full),
  .clr_ovr  (clr_ovr),
  .rx_ie    (rx_ie),
  .ovr_ie   (ovr_ie),
  .rx_full  (rx_full),
  .rx_empty (rx_empty),
  .ovr_flag (ovr_flag),
  .irq_rx   (irq_rx),
  .irq_ovr  (irq_ovr),
  .int_full (int_full)
);

// File: tb/test_spi_rx_stage.sv
module test_spi_rx_stage;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, in_valid = 1'b0, err_valid = 1'b0;
  logic rd_strobe = 1'b0, clr_full = 1'b0, clr_ovr = 1'b0;
  logic rx_ie = 1'b0, ovr_ie = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [2:0] in_err = '0, err_code = '0;
  logic in_ready, rd_ovr, rx_full, rx_empty, ovr_flag, irq_rx, irq_ovr;
  logic [DW-1:0] rd_data;
  logic [2:0] rd_err;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model of the requirements
  bit mvf, mif, mvo, mio, movr;
  logic [DW-1:0] mvd, mid;
  logic [2:0] mve, mie;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rx_stage #(.DATA_W(DW)) i_spi_rx_stage (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_err(in_err),
    .err_valid(err_valid), .err_code(err_code), .rd_strobe(rd_strobe),
    .clr_full(clr_full), .clr_ovr(clr_ovr), .rx_ie(rx_ie), .ovr_ie(ovr_ie),
    .rd_data(rd_data), .rd_err(rd_err), .rd_ovr(rd_ovr), .rx_full(rx_full),
    .rx_empty(rx_empty), .ovr_flag(ovr_flag), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    mvf = 0; mif = 0; mvo = 0; mio = 0; movr = 0;
    mvd = '0; mid = '0; mve = '0; mie = '0;
  endtask

  task automatic model_step();
    bit setv;
    setv = 0;
    if (!enable) begin
      model_clear();
      return;
    end
    if (mvf && (rd_strobe || clr_full)) mvf = 0;
    if (!mvf && mif) begin
      mvd = mid; mve = mie; mvo = mio; mvf = 1; mif = 0;
    end
    if (in_valid) begin
      if (!mvf) begin
        mvd = in_data; mve = in_err; mvo = 0; mvf = 1;
      end else begin
        mio = mif; setv = mif;
        mid = in_data; mie = in_err; mif = 1;
      end
    end else if (err_valid && mvf && mif) begin
      mio = 1; mie = err_code; setv = 1;
    end
    if (clr_ovr) movr = 0;
    if (setv) movr = 1;
  endtask

  task automatic compare(input string tag);
    chk(tag, "rx_full", rx_full, mvf);
    chk(tag, "rx_empty", rx_empty, !mvf);
    if (mvf) begin
      chk(tag, "rd_data", rd_data, mvd);
      chk(tag, "rd_err", rd_err, mve);
      chk(tag, "rd_ovr", rd_ovr, mvo);
    end
    chk("R6", "ovr_flag", ovr_flag, movr);
    chk("R9", "irq_rx", irq_rx, mvf && rx_ie);
    chk("R9", "irq_ovr", irq_ovr, movr && ovr_ie);
    chk("R8", "in_ready", in_ready, enable);
  endtask

  // inputs are set at a falling edge; one rising edge passes; compare at next falling edge
  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    in_valid = 0; err_valid = 0; rd_strobe = 0; clr_full = 0; clr_ovr = 0;
  endtask

  task automatic push(input logic [DW-1:0] d, input logic [2:0] e, input string tag);
    in_valid = 1; in_data = d; in_err = e;
    cycle(tag);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    chk("R10", "rx_full", rx_full, 0);
    chk("R10", "rx_empty", rx_empty, 1);
    chk("R10", "ovr_flag", ovr_flag, 0);
    chk("R10", "rd_data", rd_data, 0);
    chk("R10", "rd_err", rd_err, 0);
    chk("R10", "rd_ovr", rd_ovr, 0);
    rst_n = 1;
    @(negedge clk);

    // directed: two-read recovery after overrun
    enable = 1; rx_ie = 1; ovr_ie = 1;
    push(16'h0A01, 3'b001, "R1");
    push(16'h0A02, 3'b010, "R2");
    push(16'h0A03, 3'b100, "R5");
    rd_strobe = 1; cycle("R3");
    chk("R5", "rd_data overrun word", rd_data, 16'h0A03);
    chk("R5", "rd_ovr", rd_ovr, 1);
    rd_strobe = 1; cycle("R3");
    chk("R6", "ovr_flag after reads", ovr_flag, 1);
    clr_ovr = 1; cycle("R6");

    // sweep: start occupancy x strobe pattern
    for (int pre = 0; pre < 3; pre++) begin
      for (int op = 0; op < 32; op++) begin
        enable = 0; cycle("R8");
        enable = 1;
        rx_ie = op[0]; ovr_ie = op[1] ^ op[4];
        for (int k = 0; k < pre; k++)
          push(DW'(pre * 4096 + op * 16 + k), 3'(k + op), pre == 2 && k == 1 ? "R2" : "R1");
        rd_strobe = op[0]; clr_full = op[1]; clr_ovr = op[2];
        in_valid = op[3]; in_data = DW'(16'hC000 + op); in_err = 3'(op >> 1);
        err_valid = op[4]; err_code = 3'(7 - op % 8);
        if (pre == 2 && op[3] && !op[0] && !op[1]) cycle("R5");
        else if (pre == 2 && op[4] && !op[3] && !op[0] && !op[1]) cycle("R7");
        else if (pre == 0 && (op[0] || op[1]) && !op[3]) cycle("R11");
        else if (op[1]) cycle("R4");
        else if (op[0]) cycle("R3");
        else cycle("R1");
        rd_strobe = 1; cycle("R3");
        rd_strobe = 1; cycle("R3");
        if (op[2]) begin
          enable = 0; in_valid = 1; rd_strobe = 1; cycle("R8");
          enable = 1;
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule